// File: doc/BRIEF.md
# I2C Register-File Slave with Auto-Increment

This block is an I2C target that lets a bus master read and write a register file of up to 128 byte-wide locations, addressed by a 7-bit pointer. The register file sits outside the block. The slave reaches it through two ports:

- a one-cycle write strobe that carries an address and a data byte;
- a read port that presents an address and takes back the stored byte combinationally.

SCL and SDA are sampled with a fast system clock through a two-flop synchroniser. START and STOP are recognised as SDA edges while SCL is high.

The slave answers a 7-bit device address. Five high bits are fixed by a parameter, and the two low bits come from a single strap pin as the pair (~strap, strap). The byte that follows a write address loads the register pointer.

A mode input selects between two ways of using the pointer:

- **Alternating mode:** every data byte is preceded by its own pointer byte.
- **Auto-increment mode:** the pointer steps after each data byte. The pointer has a ceiling, `PTR_LAST` (0x4F by default).
  - Reads past the ceiling wrap to 0x00.
  - In a write, the byte that follows the one stored at the ceiling is taken as a fresh pointer, and stepping resumes from there.

Top module: `i2c_rf_slave`

## Requirements
- R1: The slave acknowledges only the device address {DEV_BASE, ~addr_strap, addr_strap} (7 bits, sent MSB first, followed by the R/W bit, where 1 means read). Any other address gets no ACK, and every later byte is ignored (no ACK, no write strobe) until the next START.
- R2: A STOP returns the slave to idle with SDA released, and bytes clocked after it are not acknowledged. A repeated START ends any auto-increment sequence: the first byte after the new write address is a pointer, not data.
- R3: The slave drives ACK low on the ninth clock of every byte it accepts: the matched address, pointer bytes and data bytes. Its SDA drive changes only while SCL is low.
- R4: In the pointer byte, bit 7 is ignored and bits 6:0 become the register pointer.
- R5: In alternating mode (autoinc_en=0), a write stores one data byte at the pointer, and the next byte received is a new pointer byte.
- R6: In auto-increment mode (autoinc_en=1), each written byte goes to the pointer, and the pointer then steps by one. After the byte stored at PTR_LAST, the next byte received loads the pointer instead of being stored.
- R7: A read (START, write address, pointer byte, repeated START, address with R/W=1) returns the byte at the pointer, MSB first. In auto-increment mode each master ACK steps the pointer, wrapping from PTR_LAST to 0x00.
- R8: In alternating mode the pointer does not move during a read, so consecutive acknowledged read bytes all return the same location.
- R9: A master NACK ends a read. The slave releases SDA and drives nothing until the next START.
- R10: Each accepted data byte produces exactly one single-cycle wr_en pulse, with wr_addr equal to the pointer and wr_data equal to the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_strap | input | 1 | Selects the two low device-address bits |
| autoinc_en | input | 1 | 1 = auto-increment mode, 0 = alternating mode |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 7 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_addr | output | 7 | Register read address (current pointer) |
| rd_data | input | 8 | Register read data for rd_addr |

## Verification
Address matching is tried with both strap settings and with the swapped address pair. This tells a correct strap decode apart from a decode that ignores the strap.

Several write patterns are applied:
- alternating writes whose pointer bytes have bit 7 set;
- an auto-increment burst that crosses the 0x4F ceiling;
- a full auto-increment write of locations 0x00 to 0x4F, read back in one burst that runs past the wrap.

Together these separate the write-side ceiling behaviour from the read-side wrap.

Two further patterns each separate one termination path:
- A read in alternating mode shows whether the pointer stays fixed during a read.
- A repeated START in the middle of a burst, and a read ended by a NACK and followed by extra clocks, show whether each way of ending a transfer works.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  localparam int PTR_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEV  = 3'd1,
    ST_REG  = 3'd2,
    ST_WR   = 3'd3,
    ST_RD   = 3'd4
  } rf_state_e;

  // 7-bit target address: fixed high part, then the strap pair (~strap, strap)
  function automatic logic [PTR_W-1:0] dev_address(input logic [4:0] base, input logic strap);
    return {base, ~strap, strap};
  endfunction

  // Pointer step with a ceiling: the ceiling value wraps to zero
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction

endpackage

// File: rtl/i2c_rf_line_sync.sv
module i2c_rf_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus level is high, so every flop resets to 1 and no event fires after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rf_ptr.sv
module i2c_rf_ptr
  import i2c_rf_pkg::*;
#(
  parameter logic [PTR_W-1:0] LAST = 7'h4F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr,
  output logic             at_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr_step(ptr, LAST);
  end

  assign at_last = (ptr == LAST);

endmodule

// File: rtl/i2c_rf_slave.sv
module i2c_rf_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [4:0]       DEV_BASE    = 5'b11101,
  parameter logic [PTR_W-1:0] PTR_LAST    = 7'h4F,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  input  logic              autoinc_en,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);

  // Bus events, brought out as named wires for the checker
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  rf_state_e          st, nxt_st;
  logic [CNT_W-1:0]   bitcnt;
  logic               in_ack;
  logic [BYTE_W-1:0]  shreg, txreg;
  logic               oe_q, wr_q;
  logic [PTR_W-1:0]   waddr_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic [PTR_W-1:0]   ptr;
  logic               at_last;

  logic byte_done, dev_match, ptr_load, ptr_adv, mack_rise;

  i2c_rf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  // A received byte is complete on the SCL fall after its eighth bit
  assign byte_done = scl_fall && !in_ack && (bitcnt == BYTE_END) && !start_evt && !stop_evt
                     && (st == ST_DEV || st == ST_REG || st == ST_WR);
  assign dev_match = (shreg[BYTE_W-1:1] == dev_address(DEV_BASE, addr_strap));
  assign mack_rise = scl_rise && in_ack && (st == ST_RD) && !start_evt && !stop_evt;
  assign ptr_load  = byte_done && (st == ST_REG);
  assign ptr_adv   = (byte_done && (st == ST_WR) && autoinc_en && !at_last)
                   || (mack_rise && !sda_s && autoinc_en);

  i2c_rf_ptr #(.LAST(PTR_LAST)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (shreg[PTR_W-1:0]),
    .adv      (ptr_adv),
    .ptr      (ptr),
    .at_last  (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      nxt_st  <= ST_IDLE;
      bitcnt  <= '0;
      in_ack  <= 1'b0;
      shreg   <= '0;
      txreg   <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (start_evt) begin
        st     <= ST_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        oe_q   <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        oe_q   <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (!in_ack && bitcnt != BYTE_END) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (mack_rise) begin
            nxt_st <= sda_s ? ST_IDLE : ST_RD;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            // End of the acknowledge slot
            in_ack <= 1'b0;
            bitcnt <= '0;
            st     <= nxt_st;
            if (nxt_st == ST_RD) begin
              oe_q  <= ~rd_data[BYTE_W-1];
              txreg <= {rd_data[BYTE_W-2:0], 1'b0};
            end else begin
              oe_q  <= 1'b0;
            end
          end else if (bitcnt == BYTE_END) begin
            if (st == ST_RD) begin
              oe_q   <= 1'b0;
              in_ack <= 1'b1;
              nxt_st <= ST_IDLE;
            end else if (st == ST_DEV && !dev_match) begin
              st <= ST_IDLE;
            end else begin
              in_ack <= 1'b1;
              oe_q   <= 1'b1;
              unique case (st)
                ST_DEV:  nxt_st <= shreg[0] ? ST_RD : ST_REG;
                ST_REG:  nxt_st <= ST_WR;
                ST_WR: begin
                  wr_q    <= 1'b1;
                  waddr_q <= ptr;
                  wdata_q <= shreg;
                  nxt_st  <= (autoinc_en && !at_last) ? ST_WR : ST_REG;
                end
                default: nxt_st <= ST_IDLE;
              endcase
            end
          end else if (st == ST_RD && bitcnt != '0) begin
            oe_q  <= ~txreg[BYTE_W-1];
            txreg <= {txreg[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
  assign rd_addr = ptr;

endmodule

// File: rtl/i2c_rf_slave_chk.sv
module i2c_rf_slave_chk
  import i2c_rf_pkg::*;
#(
  parameter logic [PTR_W-1:0] PTR_LAST = 7'h4F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_evt,
  input logic             stop_evt,
  input rf_state_e        st,
  input logic             sda_oe,
  input logic             wr_en,
  input logic             autoinc_en,
  input logic [PTR_W-1:0] rd_addr
);

  assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE && !sda_oe));

  assert_start_dev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_DEV));

  assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !wr_en);

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_rd_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && autoinc_en && !$stable(rd_addr))
      |-> rd_addr == (($past(rd_addr) == PTR_LAST) ? '0 : $past(rd_addr) + 1'b1));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && $past(st) == ST_RD && !autoinc_en) |-> $stable(rd_addr));

endmodule

bind i2c_rf_slave i2c_rf_slave_chk #(.PTR_LAST(PTR_LAST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .st         (st),
  .sda_oe     (sda_oe),
  .wr_en      (wr_en),
  .autoinc_en (autoinc_en),
  .rd_addr    (rd_addr)
);

// File: tb/i2c_rf_slave_tb.sv
module i2c_rf_slave_tb;

  localparam int Q = 4;  // quarter SCL period in clk cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       strap = 1'b0, autoinc = 1'b0;
  logic       sda_oe, wr_en;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       sda_line;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int n_run = 0, n_fail = 0, wr_cnt = 0, r3_viol = 0, r10_viol = 0;
  logic oe_prev = 1'b0, wr_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_rf_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .autoinc_en(autoinc), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 3) ^ 8'hA5);
  endfunction

  // Register file model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end
  assign rd_data = mem[rd_addr];

  // Monitors: write pulses and SDA drive changes while SCL is high
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) wr_cnt++;
      if (wr_en && wr_prev) r10_viol++;
      if (scl_m && (sda_oe !== oe_prev)) r3_viol++;
    end
    wr_prev = wr_en;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; tick(Q);
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
    end
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; sda_m = 1'b1; tick(2*Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
    end
    scl_m = 1'b0; tick(Q);
    sda_m = nack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev_byte(input logic s, input logic rw);
    return {5'b11101, ~s, s, rw};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int w0;
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R3 reset sda_oe", 32'(sda_oe), 0);
    chk(wr_en == 1'b0, "R10 reset wr_en", 32'(wr_en), 0);

    // R1/R4: both straps, matching and swapped addresses, pointer bit 7 set
    autoinc = 1'b0;
    for (int s = 0; s < 2; s++) begin
      strap = 1'(s);
      tick(4);
      w0 = wr_cnt;
      bus_start();
      put_byte(dev_byte(1'(s), 1'b0), ack); chk(ack, "R1 match ack", 32'(ack), 1);
      put_byte(8'h80 | 8'(5 + s), ack);     chk(ack, "R3 pointer ack", 32'(ack), 1);
      put_byte(8'hA0 + 8'(s), ack);         chk(ack, "R3 data ack", 32'(ack), 1);
      exp_mem[5 + s] = 8'hA0 + 8'(s);
      bus_stop();
      chk(wr_cnt == w0 + 1, "R10 one strobe", 32'(wr_cnt - w0), 1);
      chk(mem[5 + s] == exp_mem[5 + s], "R4 bit7 ignored", 32'(mem[5 + s]), 32'(exp_mem[5 + s]));
      w0 = wr_cnt;
      bus_start();
      put_byte(dev_byte(1'(s ^ 1), 1'b0), ack); chk(!ack, "R1 swapped nack", 32'(ack), 0);
      put_byte(8'h07, ack);                     chk(!ack, "R1 ignored byte", 32'(ack), 0);
      put_byte(8'h3C, ack);                     chk(!ack, "R1 ignored byte2", 32'(ack), 0);
      bus_stop();
      chk(wr_cnt == w0, "R1 no write", 32'(wr_cnt - w0), 0);
    end
    strap = 1'b0;

    // R5: alternating writes
    w0 = wr_cnt;
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h20, ack); put_byte(8'h11, ack);
    put_byte(8'h33, ack); chk(ack, "R5 second pointer ack", 32'(ack), 1);
    put_byte(8'h22, ack);
    bus_stop();
    exp_mem[8'h20] = 8'h11; exp_mem[8'h33] = 8'h22;
    chk(mem[8'h20] == 8'h11, "R5 first", 32'(mem[8'h20]), 32'h11);
    chk(mem[8'h33] == 8'h22, "R5 second", 32'(mem[8'h33]), 32'h22);
    chk(mem[8'h21] == exp_mem[8'h21], "R5 no step", 32'(mem[8'h21]), 32'(exp_mem[8'h21]));
    chk(wr_cnt == w0 + 2, "R10 two strobes", 32'(wr_cnt - w0), 2);

    // R6: auto-increment across the ceiling
    autoinc = 1'b1;
    tick(4);
    w0 = wr_cnt;
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h4C, ack);
    for (int k = 0; k < 4; k++) begin
      put_byte(8'hC0 + 8'(k), ack);
      exp_mem[8'h4C + k] = 8'hC0 + 8'(k);
    end
    put_byte(8'h90, ack); chk(ack, "R6 new start ack", 32'(ack), 1);
    put_byte(8'h77, ack); put_byte(8'h78, ack);
    bus_stop();
    exp_mem[8'h10] = 8'h77; exp_mem[8'h11] = 8'h78;
    for (int k = 8'h4C; k <= 8'h4F; k++)
      chk(mem[k] == exp_mem[k], "R6 burst", 32'(mem[k]), 32'(exp_mem[k]));
    chk(mem[8'h10] == 8'h77, "R6 restart addr", 32'(mem[8'h10]), 32'h77);
    chk(mem[8'h11] == 8'h78, "R6 restart step", 32'(mem[8'h11]), 32'h78);
    chk(mem[8'h50] == exp_mem[8'h50], "R6 past ceiling untouched", 32'(mem[8'h50]), 32'(exp_mem[8'h50]));
    chk(wr_cnt == w0 + 6, "R10 burst strobes", 32'(wr_cnt - w0), 6);

    // R6/R7: fill 0x00..0x4F, read back past the wrap
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h00, ack);
    for (int k = 0; k < 80; k++) begin
      put_byte(8'((k * 37 + 11)), ack);
      exp_mem[k] = 8'((k * 37 + 11));
    end
    bus_stop();
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h00, ack);
    bus_start();
    put_byte(dev_byte(0, 1), ack); chk(ack, "R7 read address ack", 32'(ack), 1);
    for (int k = 0; k < 82; k++) begin
      get_byte(k == 81, rb);
      chk(rb == exp_mem[k % 80], "R7 wrap read", 32'(rb), 32'(exp_mem[k % 80]));
    end
    bus_stop();

    // R8: alternating read keeps the pointer
    autoinc = 1'b0;
    tick(4);
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h4F, ack);
    bus_start();
    put_byte(dev_byte(0, 1), ack);
    for (int k = 0; k < 3; k++) begin
      get_byte(k == 2, rb);
      chk(rb == exp_mem[8'h4F], "R8 same location", 32'(rb), 32'(exp_mem[8'h4F]));
    end
    bus_stop();

    // R9: NACK ends a read, slave stays off the bus
    autoinc = 1'b1;
    tick(4);
    w0 = wr_cnt;
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h02, ack);
    bus_start();
    put_byte(dev_byte(0, 1), ack);
    get_byte(1'b1, rb);
    chk(rb == exp_mem[2], "R9 read before nack", 32'(rb), 32'(exp_mem[2]));
    chk(sda_oe == 1'b0, "R9 released", 32'(sda_oe), 0);
    get_byte(1'b1, rb);
    chk(rb == 8'hFF, "R9 no drive after nack", 32'(rb), 32'hFF);
    bus_stop();
    chk(wr_cnt == w0, "R9 no writes", 32'(wr_cnt - w0), 0);

    // R2: STOP then bytes without START, and repeated START ends a burst
    put_byte(dev_byte(0, 0), ack);
    chk(!ack, "R2 idle after stop", 32'(ack), 0);
    bus_stop();
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h40, ack);
    put_byte(8'h99, ack);
    exp_mem[8'h40] = 8'h99;
    bus_start();
    put_byte(dev_byte(0, 0), ack);
    put_byte(8'h42, ack); chk(ack, "R2 pointer after restart", 32'(ack), 1);
    put_byte(8'h5E, ack);
    exp_mem[8'h42] = 8'h5E;
    bus_stop();
    chk(mem[8'h40] == 8'h99, "R2 before restart", 32'(mem[8'h40]), 32'h99);
    chk(mem[8'h41] == exp_mem[8'h41], "R2 burst ended", 32'(mem[8'h41]), 32'(exp_mem[8'h41]));
    chk(mem[8'h42] == 8'h5E, "R2 new pointer", 32'(mem[8'h42]), 32'h5E);

    // Whole register file against the model
    for (int k = 0; k < 128; k++)
      chk(mem[k] == exp_mem[k], "R10 final contents", 32'(mem[k]), 32'(exp_mem[k]));
    chk(r3_viol == 0, "R3 drive changed with SCL high", 32'(r3_viol), 0);
    chk(r10_viol == 0, "R10 strobe longer than one cycle", 32'(r10_viol), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule